// File: doc/BRIEF.md
# Receive-FIFO Serial Port Register Block

This block is the software-visible register file of a serial port that buffers received bytes in a 16-entry circular queue. A simple synchronous register bus writes and reads byte-wide registers. The bit-level line logic sits outside the block. That logic hands in each received byte with a valid strobe, signals a line break with a break strobe, and takes each transmitted byte from a strobed output.

Software chooses how many buffered bytes raise the receive-full flag and the receive interrupt. Every status flag is cleared by writing a zero to its bit, and a one written to a bit leaves that flag alone. Some registers discard certain bits on write. Reads are registered, so the data for a read appears on `bus_rdata` in the cycle after `bus_rd`. A read of the receive data register removes the oldest byte from the queue.

Top module: `serial_rx_fifo_regs`

## Requirements
- R1: The receive queue holds up to 16 bytes and returns them oldest first. A byte that arrives while 16 are held is dropped. A read of offset 0x1C returns the number of bytes held.
- R2: A byte on `rx_data` with `rx_valid` is stored only while control bit 4 (offset 0x08) is 1. While that bit is 0 the byte is ignored and the count stays unchanged.
- R3: Bits 7:6 of the queue-control register (offset 0x18) select the trigger level: code 0 gives 1 byte, code 1 gives 4, code 2 gives 8 and code 3 gives 14. After reset the code is 0. When a byte is stored and the count becomes at least the trigger level, status bit 1 (receive-full) is set.
- R4: A read of offset 0x14 while bytes are held returns the oldest byte and removes it. If the count then falls below the trigger level, receive-full is cleared. A read of 0x14 while the queue is empty returns 0 and changes nothing. A read of an unmapped offset returns 0.
- R5: A write to offset 0x18 with bit 1 set empties the queue and resets its count to 0. The written value reads back from 0x18.
- R6: `rx_irq` is set in the same cycle as receive-full when control bit 6 is 1. It stays set until a control write with bit 6 at 0, or a status write with bit 1 or bit 0 at 0. Popping bytes does not clear it.
- R7: Status (offset 0x10) reports transmit-end in bit 6, transmit-empty in bit 5, break in bit 4 and receive-full in bit 1. All other bits read 0. A 0 written to bit 6, 5, 4 or 1 clears that flag, and a 1 leaves it unchanged.
- R8: A write to offset 0x0C puts the byte on `tx_data` and pulses `tx_strobe` high for exactly one cycle, the cycle after the write. The same write clears transmit-empty.
- R9: A control write with bit 5 at 0 sets transmit-end. A status read while control bit 5 is 1 returns the current flags and then sets both transmit-empty and transmit-end. While control bit 5 is 0, a status read changes nothing.
- R10: `tx_irq` equals control bit 7.
- R11: A pulse on `rx_break` sets status bit 4, which stays set until a 0 is written to that bit. When both happen in the same cycle, the break wins.
- R12: On write, the mode register (0x00) keeps only the bits in 0x7B, control keeps 0xFA and the port register (0x20) keeps 0xF3. The rate register (0x04) and queue control keep all bits. Each of these registers reads back at its own offset.
- R13: After reset, status reads 0x60, control 0x20, rate 0xFF, mode, port and queue control 0, the count 0, and both interrupts and `tx_strobe` are low.
- R14: When a byte is stored and a byte is popped in the same cycle, the count is unchanged and the popped byte is the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 8 | Read data, valid the cycle after bus_rd |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_break | input | 1 | Line break strobe |
| tx_data | output | 8 | Byte to transmit |
| tx_strobe | output | 1 | One-cycle transmit strobe |
| rx_irq | output | 1 | Receive interrupt level |
| tx_irq | output | 1 | Transmit interrupt level |

## Verification
The bench builds the block with its default parameters: a queue depth of 16 and an 8-bit address. At that depth, 17 pushes are enough to reach the full-queue drop and to wrap both pointers. Each of the four trigger codes, including the 14-byte level, can then be walked from one byte below its threshold to the threshold. The bench also drives a push and a pop in the same cycle, and a break strobe against status writes of one and of zero.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OFF_MODE = 8'h00;
    localparam logic [7:0] OFF_RATE = 8'h04;
    localparam logic [7:0] OFF_CTRL = 8'h08;
    localparam logic [7:0] OFF_TXD  = 8'h0C;
    localparam logic [7:0] OFF_STAT = 8'h10;
    localparam logic [7:0] OFF_RXD  = 8'h14;
    localparam logic [7:0] OFF_QCTL = 8'h18;
    localparam logic [7:0] OFF_QCNT = 8'h1C;
    localparam logic [7:0] OFF_PORT = 8'h20;

    localparam logic [7:0] KEEP_MODE = 8'h7B;
    localparam logic [7:0] KEEP_CTRL = 8'hFA;
    localparam logic [7:0] KEEP_PORT = 8'hF3;
    localparam logic [7:0] INIT_CTRL = 8'h20;
    localparam logic [7:0] INIT_RATE = 8'hFF;

    // control bits
    localparam int C_TXIE = 7;
    localparam int C_RXIE = 6;
    localparam int C_TXEN = 5;
    localparam int C_RXEN = 4;
    // status bits
    localparam int S_TEND = 6;
    localparam int S_TEMP = 5;
    localparam int S_BRK  = 4;
    localparam int S_FULL = 1;
    localparam int S_RDY  = 0;
    // queue control bits
    localparam int Q_FLUSH = 1;

    typedef struct packed {
        logic tx_end;
        logic tx_empty;
        logic brk;
        logic rx_full;
    } flags_t;

    function automatic logic [7:0] trig_level(input logic [1:0] code);
        case (code)
            2'd0:    return 8'd1;
            2'd1:    return 8'd4;
            2'd2:    return 8'd8;
            default: return 8'd14;
        endcase
    endfunction

    function automatic logic [7:0] status_byte(input flags_t f);
        logic [7:0] b;
        b         = '0;
        b[S_TEND] = f.tx_end;
        b[S_TEMP] = f.tx_empty;
        b[S_BRK]  = f.brk;
        b[S_FULL] = f.rx_full;
        return b;
    endfunction
endpackage

// File: rtl/srf_rx_fifo.sv
module srf_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             flush,
    input  logic [W-1:0]     din,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             push_ok,
    output logic             pop_ok
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;

    assign push_ok = push && !flush && (count != CNT_W'(DEPTH));
    assign pop_ok  = pop  && !flush && (count != '0);
    assign dout    = mem[rd_ptr];

    always_comb begin
        if (flush)
            cnt_nxt = '0;
        else
            cnt_nxt = count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= cnt_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/srf_status.sv
module srf_status
    import srf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_ok,
    input  logic             pop_ok,
    input  logic [CNT_W-1:0] cnt_nxt,
    input  logic [CNT_W-1:0] trig,
    input  logic             rx_ie,
    input  flags_t           clr,
    input  logic             irq_drop,
    input  logic             tend_set,
    input  logic             tx_refill,
    input  logic             tx_take,
    input  logic             brk_in,
    output flags_t           flags,
    output logic             rx_irq
);
    flags_t f_n;
    logic   irq_n;
    logic   reach;

    assign reach = push_ok && (cnt_nxt >= trig);

    always_comb begin
        f_n   = flags;
        irq_n = rx_irq;
        if (reach)
            f_n.rx_full = 1'b1;
        else if (pop_ok && (cnt_nxt < trig))
            f_n.rx_full = 1'b0;
        if (reach && rx_ie) irq_n = 1'b1;
        if (tx_refill) begin
            f_n.tx_end   = 1'b1;
            f_n.tx_empty = 1'b1;
        end
        if (tx_take)  f_n.tx_empty = 1'b0;
        if (tend_set) f_n.tx_end   = 1'b1;
        f_n = f_n & ~clr;
        if (irq_drop) irq_n = 1'b0;
        if (brk_in)   f_n.brk = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags  <= '{tx_end: 1'b1, tx_empty: 1'b1, brk: 1'b0, rx_full: 1'b0};
            rx_irq <= 1'b0;
        end else begin
            flags  <= f_n;
            rx_irq <= irq_n;
        end
    end
endmodule

// File: rtl/serial_rx_fifo_regs.sv
module serial_rx_fifo_regs
    import srf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    input  logic              rx_break,
    output logic [7:0]        tx_data,
    output logic              tx_strobe,
    output logic              rx_irq,
    output logic              tx_irq
);
    logic [7:0] mode_q, rate_q, ctrl_q, qctl_q, port_q;
    logic [7:0] rdata_q, txd_q;
    logic       stb_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    logic wr_ctrl, wr_txd, wr_stat, wr_qctl, rd_stat, rd_rxd;
    assign wr_ctrl = bus_wr && hit(bus_addr, OFF_CTRL);
    assign wr_txd  = bus_wr && hit(bus_addr, OFF_TXD);
    assign wr_stat = bus_wr && hit(bus_addr, OFF_STAT);
    assign wr_qctl = bus_wr && hit(bus_addr, OFF_QCTL);
    assign rd_stat = bus_rd && hit(bus_addr, OFF_STAT);
    assign rd_rxd  = bus_rd && hit(bus_addr, OFF_RXD);

    logic [BYTE_W-1:0] fifo_dout;
    logic [CNT_W-1:0]  fifo_cnt, fifo_nxt, trig;
    logic              push_ok, pop_ok;

    srf_rx_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) fifo_i (
        .clk(clk), .rst(rst),
        .push(rx_valid && ctrl_q[C_RXEN]),
        .pop(rd_rxd),
        .flush(wr_qctl && bus_wdata[Q_FLUSH]),
        .din(rx_data), .dout(fifo_dout),
        .count(fifo_cnt), .cnt_nxt(fifo_nxt),
        .push_ok(push_ok), .pop_ok(pop_ok)
    );

    assign trig = CNT_W'(trig_level(qctl_q[7:6]));

    flags_t clr_m, flags;
    always_comb begin
        clr_m = '0;
        if (wr_stat) begin
            clr_m.tx_end   = !bus_wdata[S_TEND];
            clr_m.tx_empty = !bus_wdata[S_TEMP];
            clr_m.brk      = !bus_wdata[S_BRK];
            clr_m.rx_full  = !bus_wdata[S_FULL];
        end
    end

    srf_status #(.CNT_W(CNT_W)) stat_i (
        .clk(clk), .rst(rst),
        .push_ok(push_ok), .pop_ok(pop_ok),
        .cnt_nxt(fifo_nxt), .trig(trig),
        .rx_ie(ctrl_q[C_RXIE]),
        .clr(clr_m),
        .irq_drop((wr_ctrl && !bus_wdata[C_RXIE]) ||
                  (wr_stat && !(bus_wdata[S_FULL] && bus_wdata[S_RDY]))),
        .tend_set(wr_ctrl && !bus_wdata[C_TXEN]),
        .tx_refill(rd_stat && ctrl_q[C_TXEN]),
        .tx_take(wr_txd),
        .brk_in(rx_break),
        .flags(flags), .rx_irq(rx_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            rate_q <= INIT_RATE;
            ctrl_q <= INIT_CTRL;
            qctl_q <= '0;
            port_q <= '0;
            txd_q  <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= wr_txd;
            if (bus_wr) begin
                if (hit(bus_addr, OFF_MODE)) mode_q <= bus_wdata & KEEP_MODE;
                if (hit(bus_addr, OFF_RATE)) rate_q <= bus_wdata;
                if (hit(bus_addr, OFF_PORT)) port_q <= bus_wdata & KEEP_PORT;
                if (wr_ctrl) ctrl_q <= bus_wdata & KEEP_CTRL;
                if (wr_qctl) qctl_q <= bus_wdata;
                if (wr_txd)  txd_q  <= bus_wdata;
            end
        end
    end

    logic [7:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if      (hit(bus_addr, OFF_MODE)) rd_mux = mode_q;
        else if (hit(bus_addr, OFF_RATE)) rd_mux = rate_q;
        else if (hit(bus_addr, OFF_CTRL)) rd_mux = ctrl_q;
        else if (hit(bus_addr, OFF_STAT)) rd_mux = status_byte(flags);
        else if (hit(bus_addr, OFF_RXD))  rd_mux = pop_ok ? fifo_dout : 8'h00;
        else if (hit(bus_addr, OFF_QCTL)) rd_mux = qctl_q;
        else if (hit(bus_addr, OFF_QCNT)) rd_mux = 8'(fifo_cnt);
        else if (hit(bus_addr, OFF_PORT)) rd_mux = port_q;
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign tx_data   = txd_q;
    assign tx_strobe = stb_q;
    assign tx_irq    = ctrl_q[C_TXIE];
endmodule

// File: rtl/srf_check.sv
module srf_check
    import srf_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic              rx_valid,
    input logic              rx_break,
    input logic [7:0]        tx_data,
    input logic              tx_strobe,
    input logic              rx_irq,
    input logic              rx_en,
    input logic              rx_ie,
    input logic [CNT_W-1:0]  count,
    input logic              brk
);
    logic pop_req, flush_req, txd_req;
    assign pop_req   = bus_rd && (bus_addr == ADDR_W'(OFF_RXD));
    assign flush_req = bus_wr && (bus_addr == ADDR_W'(OFF_QCTL)) && bus_wdata[Q_FLUSH];
    assign txd_req   = bus_wr && (bus_addr == ADDR_W'(OFF_TXD));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_full_drop_R1: assert property (@(posedge clk) disable iff (rst)
        (count == CNT_W'(DEPTH) && rx_valid && !pop_req && !flush_req) |=> (count == CNT_W'(DEPTH)));

    assert_rx_disabled_R2: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !pop_req && !flush_req) |=> (count == $past(count)));

    assert_flush_R5: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> (count == '0));

    assert_irq_enable_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past(rx_ie));

    assert_tx_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        txd_req |=> (tx_strobe && tx_data == $past(bus_wdata)));

    assert_tx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !txd_req |=> !tx_strobe);

    assert_break_R11: assert property (@(posedge clk) disable iff (rst)
        rx_break |=> brk);
endmodule

bind serial_rx_fifo_regs srf_check #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .rx_valid(rx_valid),
    .rx_break(rx_break), .tx_data(tx_data), .tx_strobe(tx_strobe),
    .rx_irq(rx_irq), .rx_en(ctrl_q[4]), .rx_ie(ctrl_q[6]),
    .count(fifo_cnt), .brk(flags.brk)
);

// File: tb/serial_rx_fifo_regs_tb_top.sv
`timescale 1ns/1ps
module serial_rx_fifo_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = '0, bus_wdata = '0, rx_data = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] bus_rdata, tx_data;
    logic       tx_strobe, rx_irq, tx_irq;
    int         total = 0, bad = 0;

    always #2.5 clk = ~clk;

    serial_rx_fifo_regs dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_break(rx_break),
        .tx_data(tx_data), .tx_strobe(tx_strobe), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // {req, op, addr, data/expected}; op 0 = write, 1 = read and compare, 2 = receive byte
    localparam int NV = 25;
    localparam logic [27:0] VEC [NV] = '{
        {4'd12, 2'd0, 8'h00, 8'hFF, 6'd0}, {4'd12, 2'd1, 8'h00, 8'h7B, 6'd0}, // R12 mode mask
        {4'd12, 2'd0, 8'h08, 8'hFF, 6'd0}, {4'd12, 2'd1, 8'h08, 8'hFA, 6'd0}, // R12 control mask
        {4'd12, 2'd0, 8'h20, 8'hFF, 6'd0}, {4'd12, 2'd1, 8'h20, 8'hF3, 6'd0}, // R12 port mask
        {4'd12, 2'd0, 8'h04, 8'h5A, 6'd0}, {4'd12, 2'd1, 8'h04, 8'h5A, 6'd0}, // R12 rate
        {4'd3,  2'd0, 8'h18, 8'h40, 6'd0}, {4'd3,  2'd1, 8'h18, 8'h40, 6'd0}, // R3 trigger 4
        {4'd3,  2'd2, 8'h00, 8'h11, 6'd0}, {4'd3,  2'd2, 8'h00, 8'h22, 6'd0},
        {4'd3,  2'd2, 8'h00, 8'h33, 6'd0}, {4'd3,  2'd1, 8'h10, 8'h60, 6'd0}, // R3 below level
        {4'd1,  2'd1, 8'h1C, 8'h03, 6'd0},                                    // R1 count
        {4'd3,  2'd2, 8'h00, 8'h44, 6'd0}, {4'd3,  2'd1, 8'h10, 8'h62, 6'd0}, // R3 level reached
        {4'd4,  2'd1, 8'h14, 8'h11, 6'd0}, {4'd4,  2'd1, 8'h10, 8'h60, 6'd0}, // R4 pop clears full
        {4'd1,  2'd1, 8'h14, 8'h22, 6'd0}, {4'd1,  2'd1, 8'h14, 8'h33, 6'd0}, // R1 order
        {4'd1,  2'd1, 8'h14, 8'h44, 6'd0}, {4'd4,  2'd1, 8'h14, 8'h00, 6'd0}, // R4 empty read
        {4'd4,  2'd1, 8'h1C, 8'h00, 6'd0}, {4'd4,  2'd1, 8'h3C, 8'h00, 6'd0}  // R4 count, unmapped
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R13 reset state
        check("R13 rx_irq", {7'd0, rx_irq}, 8'h00);
        check("R13 tx_irq", {7'd0, tx_irq}, 8'h00);
        check("R13 tx_strobe", {7'd0, tx_strobe}, 8'h00);
        rd_chk("R13 status", 8'h10, 8'h60);
        rd_chk("R13 control", 8'h08, 8'h20);
        rd_chk("R13 rate", 8'h04, 8'hFF);
        rd_chk("R13 mode", 8'h00, 8'h00);
        rd_chk("R13 port", 8'h20, 8'h00);
        rd_chk("R13 qctl", 8'h18, 8'h00);
        rd_chk("R13 count", 8'h1C, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [3:0] rq;
            logic [1:0] op;
            logic [7:0] ad, dt;
            {rq, op, ad, dt} = VEC[i][27:6];
            case (op)
                2'd0: wr(ad, dt);
                2'd1: begin
                    rd(ad, v);
                    total++;
                    if (v !== dt) begin
                        bad++;
                        $display("FAIL R%0d step %0d actual=%02h expected=%02h", rq, i, v, dt);
                    end
                end
                default: push(dt);
            endcase
        end

        // R6: interrupt held after pops, dropped by status write with bit 1 at 0
        check("R6 irq after pops", {7'd0, rx_irq}, 8'h01);
        wr(8'h10, 8'hFD);
        check("R6 irq status drop", {7'd0, rx_irq}, 8'h00);
        rd_chk("R7 ones keep flags", 8'h10, 8'h60);

        // R2 receive disabled, R10 transmit interrupt
        wr(8'h08, 8'hE0);
        push(8'h55);
        rd_chk("R2 ignored byte", 8'h1C, 8'h00);
        check("R10 tx_irq high", {7'd0, tx_irq}, 8'h01);
        wr(8'h08, 8'h60);
        check("R10 tx_irq low", {7'd0, tx_irq}, 8'h00);

        // R1 full queue drops the 17th byte
        wr(8'h08, 8'hF0);
        wr(8'h18, 8'h00);
        for (int i = 0; i < 17; i++) push(8'h80 + 8'(i));
        rd_chk("R1 full count", 8'h1C, 8'h10);
        for (int i = 0; i < 16; i++) rd_chk("R1 order", 8'h14, 8'h80 + 8'(i));
        rd_chk("R1 drained", 8'h14, 8'h00);

        // R5 flush
        push(8'h71); push(8'h72); push(8'h73);
        rd_chk("R5 before flush", 8'h1C, 8'h03);
        wr(8'h18, 8'h02);
        rd_chk("R5 flushed count", 8'h1C, 8'h00);
        rd_chk("R5 qctl readback", 8'h18, 8'h02);
        rd_chk("R5 nothing left", 8'h14, 8'h00);

        // R3 trigger codes 1..3
        for (int c = 1; c < 4; c++) begin
            int lvl;
            lvl = (c == 1) ? 4 : (c == 2) ? 8 : 14;
            wr(8'h18, {2'(c), 6'd0});
            wr(8'h10, 8'hFC);
            check("R6 cleared", {7'd0, rx_irq}, 8'h00);
            for (int k = 0; k < lvl - 1; k++) push(8'(k));
            rd_chk("R3 one below level", 8'h10, 8'h60);
            check("R6 quiet below level", {7'd0, rx_irq}, 8'h00);
            push(8'hEE);
            rd_chk("R3 at level", 8'h10, 8'h62);
            check("R6 raised at level", {7'd0, rx_irq}, 8'h01);
            wr(8'h18, {2'(c), 6'd2});
        end
        wr(8'h18, 8'h00);
        wr(8'h10, 8'hFC);

        // R14 push and pop in one cycle
        push(8'hA1); push(8'hA2);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hA3; bus_rd = 1'b1; bus_addr = 8'h14;
        @(negedge clk);
        rx_valid = 1'b0; bus_rd = 1'b0;
        check("R14 popped oldest", bus_rdata, 8'hA1);
        rd_chk("R14 count kept", 8'h1C, 8'h02);
        rd_chk("R14 next", 8'h14, 8'hA2);
        rd_chk("R14 last", 8'h14, 8'hA3);
        wr(8'h10, 8'hFC);

        // R8 transmit strobe
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 8'h5C;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R8 strobe high", {7'd0, tx_strobe}, 8'h01);
        check("R8 byte", tx_data, 8'h5C);
        @(negedge clk);
        check("R8 strobe one cycle", {7'd0, tx_strobe}, 8'h00);
        rd_chk("R8 tx-empty cleared", 8'h10, 8'h40);
        rd_chk("R9 refill by read", 8'h10, 8'h60);

        // R9 transmit-end from control write
        wr(8'h08, 8'h50);
        wr(8'h10, 8'h10);
        rd_chk("R9 no refill when disabled", 8'h10, 8'h00);
        wr(8'h08, 8'h50);
        rd_chk("R9 tx-end set", 8'h10, 8'h40);

        // R11 break
        @(negedge clk);
        rx_break = 1'b1;
        @(negedge clk);
        rx_break = 1'b0;
        rd_chk("R11 break set", 8'h10, 8'h50);
        wr(8'h10, 8'hFF);
        rd_chk("R11 one keeps break", 8'h10, 8'h50);
        wr(8'h10, 8'hEF);
        rd_chk("R11 zero clears break", 8'h10, 8'h40);

        // R6 drop through control bit 6
        push(8'h3A);
        check("R6 irq set", {7'd0, rx_irq}, 8'h01);
        rd_chk("R3 trigger 1 full", 8'h10, 8'h42);
        wr(8'h08, 8'h10);
        check("R6 irq ctrl drop", {7'd0, rx_irq}, 8'h00);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule